// File: doc/BRIEF.md
# Sync-Word Frame Aligner

The aligner sits behind a serial line decoder. It takes one recovered bit per strobe and finds where frames begin by looking for a fixed 32-bit synchronisation pattern. A frame is that pattern followed by 255 payload words of 32 bits each, so one frame spans 8192 bits. A transmitter repeats the pattern at that exact spacing. Finding it fixes both the frame start and the bit alignment of the words.

After the first sighting the block waits one frame length and requires the pattern again at exactly that bit position. Only then does it declare lock. While locked it packs incoming bits into words, most significant bit first. Each word goes out with a one-cycle strobe and its slot number inside the frame. The sync slot is number 0 and carries a start-of-frame flag. A missing pattern raises a one-cycle miss pulse. A second miss in a row drops lock, and the search starts again.

Top module: `sync_frame_aligner`

## Requirements
- R1: While reset is held and in the first cycle after it, `locked`, `word_valid`, `sof` and `sync_miss` are all 0.
- R2: One bit is taken on each clock where `bit_valid` is 1, and the first bit received becomes bit 31 of a word. A clock where `bit_valid` is 0 changes nothing, whatever `bit_in` holds: no output strobe follows it, and word contents and slot positions are unchanged.
- R3: While searching, and while waiting for the pattern to come back, no word and no miss pulse is output and `locked` stays 0.
- R4: Lock is declared only when the pattern is seen again exactly 8192 valid bits after the first match ended. In the clock after the last bit of that repeat, `locked` rises and the pattern is output with `word_idx` 0, `sof` 1 and `word_valid` 1.
- R5: If the bits in that expected position do not form the pattern, no lock is declared and the search resumes.
- R6: While locked, each group of 32 valid bits is output one clock after its last bit. `word_valid` is high for that single clock and `word_idx` counts 1 to 255 through the payload slots.
- R7: While locked, a payload slot whose bits equal the pattern is output as an ordinary payload word: its own index, and `sof` 0.
- R8: While locked, if slot 0 does not hold the pattern, `sync_miss` pulses for one clock and lock is kept. The received slot-0 bits are still output with index 0 and `sof` 1.
- R9: A second consecutive miss pulses `sync_miss`, drops `locked` in the same clock, and outputs no word for that slot. A correct pattern between two misses clears the count.
- R10: After lock is lost, the search restarts from scratch, and a fresh first match plus a repeat one frame later brings lock back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_in | input | 1 | Recovered serial data bit |
| bit_valid | input | 1 | High on clocks that carry a bit in `bit_in` |
| word_out | output | 32 | Assembled word, most significant bit received first |
| word_valid | output | 1 | One-clock strobe for `word_out` |
| word_idx | output | 8 | Slot of the word in the frame: 0 for the sync slot, 1 to 255 for payload |
| sof | output | 1 | High with the slot-0 word |
| locked | output | 1 | Frame alignment is confirmed |
| sync_miss | output | 1 | One-clock pulse when slot 0 lacks the pattern while locked |

## Verification
The assertions rely on two things about the input. First, `bit_valid` is a clean level sampled once per clock. Second, slot completions are always at least 32 valid bits apart, so a miss pulse or start-of-frame can never recur on the next clock. The bench drives inputs only at falling edges and builds payload words with long runs of zeros. A pattern with no zero run longer than two bits therefore never appears at an unintended bit offset while the block is searching. Idle clocks carry deliberately misleading `bit_in` values, to show that they are ignored.

// File: rtl/fa_pkg.sv
// Package: shared types for the sync-word frame aligner.
// Assumes nothing; holds only the search state encoding and the
// per-clock output command passed from the state machine to the output stage.
package fa_pkg;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } fa_state_t;

    typedef struct packed {
        logic emit;     // put the current window on the output
        logic sof;      // the emitted word belongs to slot 0
        logic miss;     // slot 0 lacked the pattern while locked
    } fa_cmd_t;

endpackage

// File: rtl/fa_sync_shifter.sv
// Module: fa_sync_shifter
// Keeps the most recent WORD_W valid bits, newest in bit 0, and flags when
// the window including the bit arriving this clock equals the pattern.
// Assumes bit_in is meaningful only while bit_valid is high.
module fa_sync_shifter #(
    parameter int                  WORD_W    = 32,
    parameter logic [WORD_W-1:0]   SYNC_WORD = 32'hF3A5_C96B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_valid,
    output logic [WORD_W-1:0] window_next,
    output logic              sync_hit
);

    logic [WORD_W-1:0] window_q;

    // Form the window as it will be once this clock's bit is shifted in.
    always_comb begin
        window_next = {window_q[WORD_W-2:0], bit_in};
        sync_hit    = bit_valid && (window_next == SYNC_WORD);
    end

    // Advance the window only on strobed bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            window_q <= '0;
        end else if (bit_valid) begin
            window_q <= window_next;
        end
    end

endmodule

// File: rtl/fa_slot_counter.sv
// Module: fa_slot_counter
// Tracks the bit position inside the current word and the word slot inside
// the frame. A restart puts it at the first payload bit, right after a
// pattern. Assumes step is high only for valid bits the aligner tracks.
module fa_slot_counter #(
    parameter int WORD_W      = 32,
    parameter int FRAME_WORDS = 256
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           step,
    input  logic                           restart,
    input  logic                           clear,
    output logic                           word_done,
    output logic [$clog2(FRAME_WORDS)-1:0] slot_idx,
    output logic                           sync_slot
);

    localparam int BITW = $clog2(WORD_W);
    localparam int IDXW = $clog2(FRAME_WORDS);
    localparam logic [BITW-1:0] LAST_BIT  = BITW'(WORD_W - 1);
    localparam logic [IDXW-1:0] LAST_SLOT = IDXW'(FRAME_WORDS - 1);

    logic [BITW-1:0] bit_q;
    logic [IDXW-1:0] slot_q;

    // Flag the bit that completes a word, and decode slot 0.
    always_comb begin
        word_done = step && (bit_q == LAST_BIT);
        slot_idx  = slot_q;
        sync_slot = (slot_q == '0);
    end

    // Step through bits and slots; the slot index wraps at the frame length.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            bit_q  <= '0;
            slot_q <= '0;
        end else if (restart) begin
            bit_q  <= '0;
            slot_q <= IDXW'(1);
        end else if (step) begin
            if (bit_q == LAST_BIT) begin
                bit_q  <= '0;
                slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fa_frame_fsm.sv
// Module: fa_frame_fsm
// Search / confirm / locked state machine. It decides, for each completed
// slot, whether to emit it, whether it is a miss, and when lock is gained or
// lost. Assumes sync_hit and word_done refer to the same incoming bit.
module fa_frame_fsm
    import fa_pkg::*;
#(
    parameter int MISS_LIMIT = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bit_valid,
    input  logic      sync_hit,
    input  logic      word_done,
    input  logic      sync_slot,
    output fa_state_t state,
    output logic      cnt_step,
    output logic      cnt_restart,
    output logic      cnt_clear,
    output fa_cmd_t   cmd
);

    localparam int MISSW = (MISS_LIMIT < 2) ? 1 : $clog2(MISS_LIMIT + 1);
    localparam logic [MISSW-1:0] MISS_LAST = MISSW'(MISS_LIMIT - 1);

    fa_state_t        state_q, state_d;
    logic [MISSW-1:0] miss_q, miss_d;

    // Next-state and command decode for the bit arriving this clock.
    always_comb begin
        state_d     = state_q;
        miss_d      = miss_q;
        cnt_restart = 1'b0;
        cnt_clear   = 1'b0;
        cmd         = '0;
        cnt_step    = bit_valid && (state_q != ST_HUNT);
        unique case (state_q)
            ST_HUNT: begin
                if (sync_hit) begin
                    state_d     = ST_VERIFY;
                    cnt_restart = 1'b1;
                end
            end
            ST_VERIFY: begin
                if (word_done && sync_slot) begin
                    if (sync_hit) begin
                        state_d  = ST_LOCKED;
                        miss_d   = '0;
                        cmd.emit = 1'b1;
                        cmd.sof  = 1'b1;
                    end else begin
                        state_d   = ST_HUNT;
                        cnt_clear = 1'b1;
                    end
                end
            end
            ST_LOCKED: begin
                if (word_done) begin
                    if (!sync_slot) begin
                        cmd.emit = 1'b1;
                    end else if (sync_hit) begin
                        cmd.emit = 1'b1;
                        cmd.sof  = 1'b1;
                        miss_d   = '0;
                    end else if (miss_q == MISS_LAST) begin
                        cmd.miss  = 1'b1;
                        state_d   = ST_HUNT;
                        cnt_clear = 1'b1;
                        miss_d    = '0;
                    end else begin
                        cmd.emit = 1'b1;
                        cmd.sof  = 1'b1;
                        cmd.miss = 1'b1;
                        miss_d   = miss_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d   = ST_HUNT;
                cnt_clear = 1'b1;
                miss_d    = '0;
            end
        endcase
    end

    // Hold the search state and the consecutive-miss count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            miss_q  <= '0;
        end else begin
            state_q <= state_d;
            miss_q  <= miss_d;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/fa_word_out.sv
// Module: fa_word_out
// Registers the emitted word, its slot and the per-slot flags. The strobes
// last one clock and the word value holds between strobes. Assumes the
// command and the window belong to the same incoming bit.
module fa_word_out
    import fa_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int IDXW   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fa_cmd_t           cmd,
    input  logic [WORD_W-1:0] window_next,
    input  logic [IDXW-1:0]   slot_idx,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid,
    output logic [IDXW-1:0]   word_idx,
    output logic              sof,
    output logic              sync_miss
);

    // Capture the word on emit; pulse the strobes for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out   <= '0;
            word_idx   <= '0;
            word_valid <= 1'b0;
            sof        <= 1'b0;
            sync_miss  <= 1'b0;
        end else begin
            word_valid <= cmd.emit;
            sof        <= cmd.emit && cmd.sof;
            sync_miss  <= cmd.miss;
            if (cmd.emit) begin
                word_out <= window_next;
                word_idx <= slot_idx;
            end
        end
    end

endmodule

// File: rtl/sync_frame_aligner.sv
// Module: sync_frame_aligner (top)
// Finds frame boundaries in a strobed serial bit stream with a fixed sync
// pattern, confirms the pattern's spacing before lock, and then outputs
// numbered words. Assumes bits arrive most significant first, at most one
// per clock, and that FRAME_WORDS counts the sync slot.
module sync_frame_aligner
    import fa_pkg::*;
#(
    parameter int                WORD_W      = 32,
    parameter int                FRAME_WORDS = 256,
    parameter int                MISS_LIMIT  = 2,
    parameter logic [WORD_W-1:0] SYNC_WORD   = 32'hF3A5_C96B
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bit_in,
    input  logic                           bit_valid,
    output logic [WORD_W-1:0]              word_out,
    output logic                           word_valid,
    output logic [$clog2(FRAME_WORDS)-1:0] word_idx,
    output logic                           sof,
    output logic                           locked,
    output logic                           sync_miss
);

    localparam int IDXW = $clog2(FRAME_WORDS);

    logic [WORD_W-1:0] window_next;
    logic              sync_hit;
    logic              word_done;
    logic              sync_slot;
    logic [IDXW-1:0]   slot_idx;
    logic              cnt_step;
    logic              cnt_restart;
    logic              cnt_clear;
    fa_state_t         state;
    fa_cmd_t           cmd;

    fa_sync_shifter #(
        .WORD_W    (WORD_W),
        .SYNC_WORD (SYNC_WORD)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_in      (bit_in),
        .bit_valid   (bit_valid),
        .window_next (window_next),
        .sync_hit    (sync_hit)
    );

    fa_slot_counter #(
        .WORD_W      (WORD_W),
        .FRAME_WORDS (FRAME_WORDS)
    ) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (cnt_step),
        .restart   (cnt_restart),
        .clear     (cnt_clear),
        .word_done (word_done),
        .slot_idx  (slot_idx),
        .sync_slot (sync_slot)
    );

    fa_frame_fsm #(
        .MISS_LIMIT (MISS_LIMIT)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_valid   (bit_valid),
        .sync_hit    (sync_hit),
        .word_done   (word_done),
        .sync_slot   (sync_slot),
        .state       (state),
        .cnt_step    (cnt_step),
        .cnt_restart (cnt_restart),
        .cnt_clear   (cnt_clear),
        .cmd         (cmd)
    );

    fa_word_out #(
        .WORD_W (WORD_W),
        .IDXW   (IDXW)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd),
        .window_next (window_next),
        .slot_idx    (slot_idx),
        .word_out    (word_out),
        .word_valid  (word_valid),
        .word_idx    (word_idx),
        .sof         (sof),
        .sync_miss   (sync_miss)
    );

    // Lock flag straight from the registered search state.
    always_comb locked = (state == ST_LOCKED);

endmodule

// File: rtl/fa_checker.sv
// Module: fa_checker
// Temporal properties over the aligner's ports, attached to every instance
// of the top module. Assumes slot completions are at least one word apart.
module fa_checker #(
    parameter int                WORD_W      = 32,
    parameter int                FRAME_WORDS = 256,
    parameter logic [WORD_W-1:0] SYNC_WORD   = 32'hF3A5_C96B
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           bit_valid,
    input logic [WORD_W-1:0]              word_out,
    input logic                           word_valid,
    input logic [$clog2(FRAME_WORDS)-1:0] word_idx,
    input logic                           sof,
    input logic                           locked,
    input logic                           sync_miss
);

    localparam int IDXW = $clog2(FRAME_WORDS);

    logic [IDXW-1:0] last_idx;
    logic            seen;

    // Remember the last emitted slot while locked, to check slot order.
    always_ff @(posedge clk) begin
        if (!rst_n || !locked) begin
            last_idx <= '0;
            seen     <= 1'b0;
        end else if (word_valid) begin
            last_idx <= word_idx;
            seen     <= 1'b1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!locked && !word_valid && !sof && !sync_miss)); // R1
    AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n) !$past(bit_valid) |-> (!word_valid && !sync_miss)); // R2
    AST_WORD_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) word_valid |-> locked); // R3
    AST_LOCK_GIVES_SOF: assert property (@(posedge clk) disable iff (!rst_n) $rose(locked) |-> (sof && word_out == SYNC_WORD)); // R4
    AST_SOF_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) sof |-> (word_valid && word_idx == '0)); // R6
    AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n) (word_valid && !sof && seen) |-> (word_idx == IDXW'(last_idx + 1'b1))); // R6
    AST_CLEAN_SYNC: assert property (@(posedge clk) disable iff (!rst_n) (sof && !sync_miss) |-> (word_out == SYNC_WORD)); // R8
    AST_MISS_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) sync_miss |-> $past(locked)); // R8
    AST_MISS_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n) sync_miss |=> !sync_miss); // R8
    AST_DROP_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n) $fell(locked) |-> (sync_miss && !word_valid)); // R9

endmodule

bind sync_frame_aligner fa_checker #(
    .WORD_W      (WORD_W),
    .FRAME_WORDS (FRAME_WORDS),
    .SYNC_WORD   (SYNC_WORD)
) u_fa_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_valid  (bit_valid),
    .word_out   (word_out),
    .word_valid (word_valid),
    .word_idx   (word_idx),
    .sof        (sof),
    .locked     (locked),
    .sync_miss  (sync_miss)
);

// File: tb/sync_frame_aligner_test.sv
// Bench: directed scenarios, each task checks its own results.
module sync_frame_aligner_test;

    localparam int          W     = 32;
    localparam int          NW    = 256;
    localparam logic [31:0] SYNC  = 32'hF3A5_C96B;
    localparam logic [31:0] BAD   = SYNC ^ 32'h0000_0100;
    localparam int          CAPN  = 600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_in = 1'b0;
    logic        bit_valid = 1'b0;
    logic [31:0] word_out;
    logic        word_valid;
    logic [7:0]  word_idx;
    logic        sof;
    logic        locked;
    logic        sync_miss;

    int checks = 0;
    int errors = 0;

    logic [31:0] cap_w [CAPN];
    int          cap_i [CAPN];
    logic        cap_s [CAPN];
    int          cap_n = 0;
    int          miss_n = 0;

    sync_frame_aligner #(
        .WORD_W(W), .FRAME_WORDS(NW), .MISS_LIMIT(2), .SYNC_WORD(SYNC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_valid(bit_valid),
        .word_out(word_out), .word_valid(word_valid), .word_idx(word_idx),
        .sof(sof), .locked(locked), .sync_miss(sync_miss)
    );

    always #5 clk = ~clk;

    // Record every output strobe at the falling edge.
    always @(negedge clk) begin
        if (rst_n && word_valid) begin
            if (cap_n < CAPN) begin
                cap_w[cap_n] = word_out;
                cap_i[cap_n] = int'(word_idx);
                cap_s[cap_n] = sof;
            end
            cap_n++;
        end
        if (rst_n && sync_miss) miss_n++;
    end

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_cap();
        cap_n  = 0;
        miss_n = 0;
    endtask

    function automatic logic [31:0] mkword(int f, int i);
        return {12'h000, 4'(f), 8'(i), 8'h00};
    endfunction

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            bit_valid = 1'b0;
            bit_in    = ~bit_in;
        end
    endtask

    task automatic send_word(logic [31:0] w, int gap);
        for (int b = 31; b >= 0; b--) begin
            @(negedge clk);
            bit_in    = w[b];
            bit_valid = 1'b1;
            if (gap != 0 && (b % gap) == 0) begin
                @(negedge clk);
                bit_valid = 1'b0;
                bit_in    = ~w[b];
            end
        end
    endtask

    task automatic send_payload(int f, int gap, bit sync_in5);
        for (int i = 1; i < NW; i++)
            send_word((sync_in5 && i == 5) ? SYNC : mkword(f, i), gap);
    endtask

    // Compare the captured payload slots starting at capture index base.
    task automatic check_payload(string tag, int base, int f, bit sync_in5);
        int bad = 0;
        for (int i = 1; i < NW; i++) begin
            logic [31:0] e;
            e = (sync_in5 && i == 5) ? SYNC : mkword(f, i);
            if (cap_w[base+i-1] !== e || cap_i[base+i-1] != i || cap_s[base+i-1] !== 1'b0)
                bad++;
        end
        check(tag, bad, 0);
    endtask

    task automatic t_reset();
        check("R1 locked", locked, 0);
        check("R1 word_valid", word_valid, 0);
        check("R1 sof", sof, 0);
        check("R1 sync_miss", sync_miss, 0);
    endtask

    task automatic t_acquire();
        clear_cap();
        send_word(32'h0000_0059, 0);
        send_word(SYNC, 0);
        send_payload(1, 0, 0);
        idle(2);
        check("R3 no output before confirm", cap_n, 0);
        check("R3 unlocked while confirming", locked, 0);
        send_word(SYNC, 0);
        idle(2);
        check("R4 one word at lock", cap_n, 1);
        check("R4 locked", locked, 1);
        check("R4 sync word", cap_w[0], SYNC);
        check("R4 slot 0", cap_i[0], 0);
        check("R4 sof", cap_s[0], 1);
        send_payload(2, 0, 0);
        send_word(SYNC, 0);
        idle(2);
        check("R6 word count", cap_n, 257);
        check_payload("R6 payload slots", 1, 2, 0);
        check("R6 next sof", cap_s[256], 1);
        check("R6 next slot 0", cap_i[256], 0);
        check("R8 no miss on good sync", miss_n, 0);
    endtask

    task automatic t_gaps_and_fake_sync();
        clear_cap();
        send_payload(3, 3, 1);
        send_word(SYNC, 3);
        idle(2);
        check("R2 word count with idle clocks", cap_n, 256);
        check_payload("R2 R7 payload with gaps and pattern in slot 5", 0, 3, 1);
        check("R7 slot 5 not sof", cap_s[4], 0);
        check("R2 sync slot", cap_i[255], 0);
        check("R2 still locked", locked, 1);
    endtask

    task automatic t_single_miss();
        clear_cap();
        send_payload(4, 0, 0);
        send_word(BAD, 0);
        idle(2);
        check("R8 one miss pulse", miss_n, 1);
        check("R8 lock kept", locked, 1);
        check("R8 slot 0 still output", cap_n, 256);
        check("R8 bad word output", cap_w[255], BAD);
        check("R8 bad word sof", cap_s[255], 1);
        send_payload(5, 0, 0);
        send_word(SYNC, 0);
        idle(2);
        check("R8 no new miss", miss_n, 1);
        check("R8 locked after good sync", locked, 1);
    endtask

    task automatic t_double_miss();
        clear_cap();
        send_payload(6, 0, 0);
        send_word(BAD, 0);
        send_payload(7, 0, 0);
        send_word(BAD, 0);
        idle(2);
        check("R9 two misses", miss_n, 2);
        check("R9 lock dropped", locked, 0);
        check("R9 no word for dropped slot", cap_n, 511);
        check("R9 last output slot", cap_i[510], 255);
    endtask

    task automatic t_verify_fail_and_relock();
        clear_cap();
        send_word(SYNC, 0);
        send_payload(8, 0, 0);
        send_word(BAD, 0);
        idle(2);
        check("R5 no output after failed confirm", cap_n, 0);
        check("R5 not locked", locked, 0);
        send_payload(9, 0, 0);
        send_word(SYNC, 0);
        send_payload(10, 0, 0);
        idle(2);
        check("R10 still unlocked during confirm", locked, 0);
        send_word(SYNC, 0);
        idle(2);
        check("R10 relocked", locked, 1);
        check("R10 one output", cap_n, 1);
        check("R10 sof word", cap_w[0], SYNC);
        check("R10 no misses", miss_n, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_acquire();
        t_gaps_and_fake_sync();
        t_single_miss();
        t_double_miss();
        t_verify_fail_and_relock();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule